// File: doc/BRIEF.md
# Priority-Key Crossbar Matching Arbiter

This block computes a crossbar match for an N-by-N input-queued switch once per cell slot. For every pairing of input port and output port, the queueing logic outside the block presents a request flag and a key. The key is the priority of the head cell of the most urgent non-empty queue for that pairing, followed by the cell's timestamp. The priority sits in the upper bits of the key, so the priority class decides first and cell age settles ties within a class.

A slot begins with a one-cycle `start` pulse. The block then runs a fixed number of rounds, one per clock. In each round, every output that is still free grants the smallest key among its requests from free inputs. Every free input that receives grants accepts the one with the smallest key. Accepted pairs join the match and are frozen for the rest of the slot. After the last round, `done` pulses for one cycle. The per-input match flags and output numbers then hold until the next `start`.

Top module: `tsmatch_arbiter`

## Requirements
- R1: In the cycle after a clock edge that samples `start` high, every `match_vld` bit is 0 and `done` is 0.
- R2: A key is `{priority, timestamp}`, with the priority in the upper PRI_W bits and the timestamp in the lower TS_W bits. A free output grants the smallest key. A lower priority value therefore wins over any timestamp of a higher priority value.
- R3: Equal keys resolve to the lower input number at an output, and to the lower output number at an input.
- R4: A free input that holds several grants accepts the one with the smallest key.
- R5: A matched pair stays matched for the rest of the slot. Later rounds consider only inputs and outputs that are still free.
- R6: Exactly ROUNDS rounds run. `done` is high for exactly one cycle, ROUNDS cycles after the `start` edge. The results then stay unchanged until the next `start`.
- R7: Each output appears in at most one match, and every matched pair had its request flag set when the slot started.
- R8: A `start` that arrives while a slot is still running discards the partial match and begins a new slot from the newly presented requests.
- R9: A slot with no request flags set ends with no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Captures the requests and begins a slot |
| req_vld | input | NPORT*NPORT | Request flag; bit i*NPORT+j means input i wants output j |
| req_key | input | NPORT*NPORT*(PRI_W+TS_W) | Key for pair (i,j) at slice index i*NPORT+j, laid out as {priority, timestamp} |
| match_vld | output | NPORT | Bit i is set when input i is matched |
| match_port | output | NPORT*IDX_W | Output matched to input i, at slice i |
| done | output | 1 | One-cycle pulse when the slot's rounds are finished |

## Verification
Two events can fall in the same cycle: a new `start`, and a round that is about to update the match registers (including the final round that raises `done`). `start` takes precedence. The bench provokes this by raising `start` with a fresh request pattern after one round of an earlier slot has already committed pairs. It then checks that the match is cleared on the next cycle, and that the final result equals the reference model's result for the new pattern alone. The same greedy software model also judges directed tie and priority patterns and several hundred seeded random slots.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
  function automatic int idx_width(int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/tsm_min_select.sv
module tsm_min_select #(
  parameter int NUM   = 4,
  parameter int KEY_W = 10,
  localparam int IW   = tsm_pkg::idx_width(NUM)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM-1:0]       cand_vld,
  input  logic [NUM*KEY_W-1:0] cand_key,
  output logic                 sel_any,
  output logic [IW-1:0]        sel_idx,
  output logic [KEY_W-1:0]     sel_key
);
  localparam int SIZE  = 1 << IW;
  localparam int NODES = 2 * SIZE - 1;

  logic             nv [NODES];
  logic [KEY_W-1:0] nk [NODES];
  logic [IW-1:0]    ni [NODES];

  // leaves: lower index sits in the left subtree
  for (genvar k = 0; k < SIZE; k++) begin : g_leaf
    if (k < NUM) begin : g_real
      assign nv[SIZE-1+k] = cand_vld[k];
      assign nk[SIZE-1+k] = cand_key[k*KEY_W +: KEY_W];
      assign ni[SIZE-1+k] = IW'(k);
    end else begin : g_pad
      assign nv[SIZE-1+k] = 1'b0;
      assign nk[SIZE-1+k] = '0;
      assign ni[SIZE-1+k] = '0;
    end
  end

  // internal nodes: right side wins only when strictly smaller
  for (genvar n = 0; n < SIZE - 1; n++) begin : g_node
    logic take_r;
    assign take_r = nv[2*n+2] && (!nv[2*n+1] || (nk[2*n+2] < nk[2*n+1]));
    assign nv[n]  = nv[2*n+1] | nv[2*n+2];
    assign nk[n]  = take_r ? nk[2*n+2] : nk[2*n+1];
    assign ni[n]  = take_r ? ni[2*n+2] : ni[2*n+1];
  end

  assign sel_any = nv[0];
  assign sel_idx = ni[0];
  assign sel_key = nk[0];

  // R2 / R3: chosen entry is minimal, ties to the lowest index
  always @(posedge clk) begin
    if (!rst) begin
      a_r9_any_matches_vld: assert (sel_any == (|cand_vld))
        else $error("min_select any flag mismatch");
      for (int k = 0; k < NUM; k++) begin
        if (cand_vld[k]) begin
          a_r2_min_key: assert (sel_key < cand_key[k*KEY_W +: KEY_W] ||
                               (sel_key == cand_key[k*KEY_W +: KEY_W] && int'(sel_idx) <= k))
            else $error("min_select not minimal at %0d", k);
        end
      end
    end
  end
endmodule

// File: rtl/tsm_round_ctl.sv
module tsm_round_ctl #(
  parameter int ROUNDS = 3,
  localparam int CW    = tsm_pkg::idx_width(ROUNDS)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  logic [CW-1:0] rnd;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      rnd  <= '0;
      done <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      rnd  <= '0;
      done <= 1'b0;
    end else if (busy) begin
      if (rnd == CW'(ROUNDS - 1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        rnd  <= rnd + 1'b1;
        done <= 1'b0;
      end
    end else begin
      done <= 1'b0;
    end
  end

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst) done |=> !done)
    else $error("done held longer than one cycle");
  a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (rst) done |-> !busy)
    else $error("done while still busy");
endmodule

// File: rtl/tsmatch_arbiter.sv
module tsmatch_arbiter #(
  parameter int NPORT  = 4,
  parameter int PRI_W  = 2,
  parameter int TS_W   = 8,
  parameter int ROUNDS = 3,
  localparam int KEY_W = PRI_W + TS_W,
  localparam int IDX_W = tsm_pkg::idx_width(NPORT)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start,
  input  logic [NPORT*NPORT-1:0]         req_vld,
  input  logic [NPORT*NPORT*KEY_W-1:0]   req_key,
  output logic [NPORT-1:0]               match_vld,
  output logic [NPORT*IDX_W-1:0]         match_port,
  output logic                           done
);
  logic [NPORT*NPORT-1:0]       q_vld;
  logic [NPORT*NPORT*KEY_W-1:0] q_key;
  logic                         busy;
  logic [NPORT-1:0]             out_taken;

  logic [NPORT-1:0]       gc_vld [NPORT];
  logic [NPORT*KEY_W-1:0] gc_key [NPORT];
  logic                   gr_any [NPORT];
  logic [IDX_W-1:0]       gr_idx [NPORT];
  logic [KEY_W-1:0]       gr_key [NPORT];

  logic [NPORT-1:0]       ac_vld [NPORT];
  logic [NPORT*KEY_W-1:0] ac_key [NPORT];
  logic                   acc_any [NPORT];
  logic [IDX_W-1:0]       acc_idx [NPORT];
  logic [KEY_W-1:0]       acc_key [NPORT];

  // capture the slot's requests (keys need no reset)
  always_ff @(posedge clk) begin
    if (rst) q_vld <= '0;
    else if (start) q_vld <= req_vld;
  end
  always_ff @(posedge clk) begin
    if (start) q_key <= req_key;
  end

  tsm_round_ctl #(.ROUNDS(ROUNDS)) ctl_i (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done)
  );

  always_comb begin
    out_taken = '0;
    for (int i = 0; i < NPORT; i++)
      if (match_vld[i]) out_taken[match_port[i*IDX_W +: IDX_W]] = 1'b1;
  end

  // grant stage: one minimum selector per output
  always_comb begin
    for (int j = 0; j < NPORT; j++) begin
      for (int i = 0; i < NPORT; i++) begin
        gc_vld[j][i] = q_vld[i*NPORT+j] & ~match_vld[i] & ~out_taken[j];
        gc_key[j][i*KEY_W +: KEY_W] = q_key[(i*NPORT+j)*KEY_W +: KEY_W];
      end
    end
  end

  for (genvar j = 0; j < NPORT; j++) begin : g_grant
    tsm_min_select #(.NUM(NPORT), .KEY_W(KEY_W)) sel_i (
      .clk(clk), .rst(rst), .cand_vld(gc_vld[j]), .cand_key(gc_key[j]),
      .sel_any(gr_any[j]), .sel_idx(gr_idx[j]), .sel_key(gr_key[j])
    );
  end

  // accept stage: one minimum selector per input
  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      for (int j = 0; j < NPORT; j++) begin
        ac_vld[i][j] = gr_any[j] && (gr_idx[j] == IDX_W'(i));
        ac_key[i][j*KEY_W +: KEY_W] = gr_key[j];
      end
    end
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_accept
    tsm_min_select #(.NUM(NPORT), .KEY_W(KEY_W)) sel_i (
      .clk(clk), .rst(rst), .cand_vld(ac_vld[i]), .cand_key(ac_key[i]),
      .sel_any(acc_any[i]), .sel_idx(acc_idx[i]), .sel_key(acc_key[i])
    );
  end

  // match registers: start clears, each round adds accepted pairs
  always_ff @(posedge clk) begin
    if (rst) begin
      match_vld  <= '0;
      match_port <= '0;
    end else if (start) begin
      match_vld  <= '0;
      match_port <= '0;
    end else if (busy) begin
      for (int i = 0; i < NPORT; i++) begin
        if (acc_any[i]) begin
          match_vld[i] <= 1'b1;
          match_port[i*IDX_W +: IDX_W] <= acc_idx[i];
        end
      end
    end
  end

  // assertions
  a_r1_start_clears: assert property (@(posedge clk) disable iff (rst)
    start |=> (match_vld == '0 && !done)) else $error("start did not clear match");

  a_r5_match_sticky: assert property (@(posedge clk) disable iff (rst)
    !start |=> ((match_vld & $past(match_vld)) == $past(match_vld)))
    else $error("a matched input was released mid-slot");

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(match_vld) && $stable(match_port)))
    else $error("match changed while idle");

  always @(posedge clk) begin
    if (!rst) begin
      for (int i = 0; i < NPORT; i++) begin
        if (match_vld[i]) begin
          a_r7_had_request: assert (q_vld[i*NPORT + int'(match_port[i*IDX_W +: IDX_W])])
            else $error("input %0d matched without request", i);
          for (int k = i + 1; k < NPORT; k++) begin
            if (match_vld[k]) begin
              a_r7_output_unique: assert (match_port[i*IDX_W +: IDX_W] != match_port[k*IDX_W +: IDX_W])
                else $error("inputs %0d and %0d share an output", i, k);
            end
          end
        end
        if (acc_any[i]) begin
          a_r4_accept_key: assert (acc_key[i] ==
              q_key[(i*NPORT + int'(acc_idx[i]))*KEY_W +: KEY_W])
            else $error("accepted key does not belong to pair");
        end
      end
    end
  end
endmodule

// File: tb/tsmatch_arbiter_tb_top.sv
module tsmatch_arbiter_tb_top;
  localparam int N      = 4;
  localparam int PRI_W  = 2;
  localparam int TS_W   = 8;
  localparam int ROUNDS = 3;
  localparam int KEY_W  = PRI_W + TS_W;
  localparam int IDX_W  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [N*N-1:0]       req_vld = '0;
  logic [N*N*KEY_W-1:0] req_key = '0;
  logic [N-1:0]         match_vld;
  logic [N*IDX_W-1:0]   match_port;
  logic                 done;

  int n_chk = 0;
  int n_bad = 0;

  bit             rv [N][N];
  logic [KEY_W-1:0] rk [N][N];
  bit             ev [N];
  int             ep [N];

  always #5 clk = ~clk;

  tsmatch_arbiter #(.NPORT(N), .PRI_W(PRI_W), .TS_W(TS_W), .ROUNDS(ROUNDS)) dut_i (
    .clk(clk), .rst(rst), .start(start), .req_vld(req_vld), .req_key(req_key),
    .match_vld(match_vld), .match_port(match_port), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [KEY_W-1:0] mk(int pri, int ts);
    return {PRI_W'(pri), TS_W'(ts)};
  endfunction

  // greedy software model of the round procedure
  task automatic ref_model();
    bit otk [N];
    int g [N];
    for (int i = 0; i < N; i++) begin ev[i] = 0; ep[i] = 0; otk[i] = 0; end
    for (int r = 0; r < ROUNDS; r++) begin
      for (int j = 0; j < N; j++) begin
        g[j] = -1;
        if (!otk[j])
          for (int i = 0; i < N; i++)
            if (rv[i][j] && !ev[i] && (g[j] < 0 || rk[i][j] < rk[g[j]][j])) g[j] = i;
      end
      for (int i = 0; i < N; i++) begin
        int bo = -1;
        if (!ev[i])
          for (int j = 0; j < N; j++)
            if (g[j] == i && (bo < 0 || rk[i][j] < rk[i][bo])) bo = j;
        if (bo >= 0) begin ev[i] = 1; ep[i] = bo; otk[bo] = 1; end
      end
    end
  endtask

  task automatic pack_reqs();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        req_vld[i*N+j] = rv[i][j];
        req_key[(i*N+j)*KEY_W +: KEY_W] = rk[i][j];
      end
  endtask

  task automatic compare(input string req);
    for (int i = 0; i < N; i++) begin
      check(match_vld[i] == ev[i], req, $sformatf("vld in%0d", i), match_vld[i], ev[i]);
      if (ev[i])
        check(int'(match_port[i*IDX_W +: IDX_W]) == ep[i], req, $sformatf("port in%0d", i),
              match_port[i*IDX_W +: IDX_W], ep[i]);
    end
  endtask

  // after the start edge: check clear, wait the rounds, check result and hold
  task automatic finish_slot(input string req);
    logic [N-1:0] hv;
    logic [N*IDX_W-1:0] hp;
    @(negedge clk);
    start = 1'b0;
    check(match_vld == '0 && !done, "R1", "cleared after start", {match_vld, done}, 0);
    for (int r = 0; r < ROUNDS - 1; r++) begin
      @(negedge clk);
      check(!done, "R6", "done early", done, 0);
    end
    @(negedge clk);
    check(done, "R6", "done pulse", done, 1);
    ref_model();
    compare(req);
    hv = match_vld; hp = match_port;
    @(negedge clk);
    check(!done && match_vld == hv && match_port == hp, "R6", "hold after done",
          {match_vld, match_port, done}, {hv, hp, 1'b0});
  endtask

  task automatic run_slot(input string req);
    @(negedge clk);
    pack_reqs();
    start = 1'b1;
    finish_slot(req);
  endtask

  task automatic clear_reqs();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin rv[i][j] = 0; rk[i][j] = '0; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(match_vld == '0 && !done, "R1", "reset state", {match_vld, done}, 0);

    // R9: empty slot
    clear_reqs();
    run_slot("R9");

    // R2: priority beats age at output 0
    clear_reqs();
    rv[0][0] = 1; rk[0][0] = mk(3, 0);
    rv[1][0] = 1; rk[1][0] = mk(0, 255);
    run_slot("R2");
    check(match_vld[1] && match_port[1*IDX_W +: IDX_W] == 0 && !match_vld[0], "R2",
          "low priority value wins", {match_vld, match_port}, 0);

    // R3: all keys equal; lowest indices win each round, input 3 starves in 3 rounds
    clear_reqs();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin rv[i][j] = 1; rk[i][j] = mk(1, 7); end
    run_slot("R3");
    check(match_port[0 +: IDX_W] == 0 && match_port[IDX_W +: IDX_W] == 1 && !match_vld[3],
          "R3", "tie to lower index", {match_vld, match_port}, 0);

    // R4: input 2 receives grants from outputs 1 and 3; takes smaller key (output 3)
    clear_reqs();
    rv[2][1] = 1; rk[2][1] = mk(1, 40);
    rv[2][3] = 1; rk[2][3] = mk(1, 12);
    run_slot("R4");
    check(match_vld[2] && match_port[2*IDX_W +: IDX_W] == 3, "R4", "smallest grant accepted",
          match_port[2*IDX_W +: IDX_W], 3);

    // R5: second round pairs leftover input/output
    clear_reqs();
    rv[0][0] = 1; rk[0][0] = mk(0, 1);
    rv[1][0] = 1; rk[1][0] = mk(0, 2);
    rv[1][1] = 1; rk[1][1] = mk(2, 2);
    rv[0][1] = 1; rk[0][1] = mk(0, 0);
    run_slot("R5");

    // R8: restart after one committed round
    clear_reqs();
    for (int i = 0; i < N; i++) begin rv[i][i] = 1; rk[i][i] = mk(0, i); end
    @(negedge clk);
    pack_reqs();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    clear_reqs();
    rv[3][0] = 1; rk[3][0] = mk(1, 5);
    pack_reqs();
    start = 1'b1;
    finish_slot("R8");

    // R7 and general: seeded random slots
    for (int s = 0; s < 300; s++) begin
      bool_loop: for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin
          rv[i][j] = ($urandom % 2) == 1;
          rk[i][j] = (s % 2 == 0) ? mk($urandom % 4, $urandom % 4) : mk($urandom, $urandom);
        end
      run_slot("R7");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule